// File: doc/BRIEF.md
# Serial Sound-Register Frame Receiver

This block is the peripheral side of an SPI link that carries register images for a sound chip. During each transaction the host clocks in a complete register set, 25 registers of 8 bits each, while chip select is low. The block shifts the bits into a 200-bit buffer. When the last bit of the frame arrives, it presents the whole image on a parallel bus in the system clock domain and marks it with a single-cycle valid strobe. The downstream writer therefore always sees an entire, consistent register set and never a partial update.

The SPI lines are asynchronous to the system clock. Each line passes through a two-stage synchroniser, and the rising edge of the serial clock is detected in the system domain. A small state machine tracks each transaction. Frames cut short by an early chip-select release are dropped. Bits sent after a frame is complete are ignored until chip select is released.

The states and transitions are:
- `ST_IDLE` moves to `ST_SHIFT` on *select* (chip select goes low).
- `ST_SHIFT` moves to `ST_FULL` on *complete* (the 200th bit is sampled).
- `ST_SHIFT` moves to `ST_IDLE` on *abort* (chip select is released early).
- `ST_FULL` moves to `ST_IDLE` on *release* (chip select goes high).

Top module: `regframe_spi_rx`

## Requirements
- R1: After reset, `frame_valid` is 0 and `frame_data` is all zeros.
- R2: SPI mode 0 is used. MOSI is sampled on each rising SCLK edge while `spi_cs_n` is low, and bits within a byte arrive most significant bit first.
- R3: The k-th byte of a transaction (k = 0..24) is register k and appears on `frame_data[8k+7:8k]`.
- R4: Receiving exactly the 200th bit of a transaction raises `frame_valid` for exactly one system clock cycle, once per transaction.
- R5: If chip select is released after fewer than 200 bits, no `frame_valid` pulse is produced and `frame_data` keeps its previous value.
- R6: `frame_data` changes only in the cycle in which `frame_valid` is high, and otherwise holds its value.
- R7: Bits clocked after the 200th bit in the same transaction are ignored. They cause no further pulse and do not alter the delivered frame.
- R8: SCLK edges while `spi_cs_n` is high are ignored. The bit count returns to zero whenever chip select is high.
- R9: A transaction that follows an aborted one is received from bit 0 and decodes correctly.
- R10: Back-to-back transactions separated by a short chip-select-high gap each deliver their own frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low chip select |
| frame_data | output | 200 | Received register image, register k in bits 8k+7:8k |
| frame_valid | output | 1 | One-cycle strobe marking new `frame_data` |

## Verification
The assertions assume that the SPI signals are slow compared with the system clock. SCLK must stay high and stay low for at least three system cycles each, so that every rising edge is seen exactly once after synchronisation. MOSI must be steady around each rising SCLK edge, and chip select may change only while SCLK is low, with some setup time before the first rising edge. The stimulus meets these conditions. It holds each SCLK phase for five system cycles, changes MOSI and chip select only in the low phase, and waits one full SCLK phase after asserting chip select before the first edge.

// File: rtl/rfrx_pkg.sv
`timescale 1ns/1ps
package rfrx_pkg;
    parameter int unsigned REG_COUNT = 25;
    parameter int unsigned REG_BITS  = 8;
    localparam int unsigned FRAME_BITS = REG_COUNT * REG_BITS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/rfrx_sync.sv
`timescale 1ns/1ps
module rfrx_sync #(
    parameter int unsigned        WIDTH   = 3,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[g] <= RST_VAL[g];
                stage2_q[g] <= RST_VAL[g];
            end else begin
                stage1_q[g] <= async_i[g];
                stage2_q[g] <= stage1_q[g];
            end
        end
    end

    assign sync_o = stage2_q;

    // R2: the synchronised output follows the first stage one cycle later
    sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage2_q == $past(stage1_q)));
endmodule

// File: rtl/rfrx_edge.sv
`timescale 1ns/1ps
module rfrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~prev_q;

    // R2: each rising serial edge produces a single-cycle strobe
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rfrx_collect.sv
`timescale 1ns/1ps
module rfrx_collect
    import rfrx_pkg::*;
#(
    parameter int unsigned FRAME_W = FRAME_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_i,
    input  logic               mosi_i,
    input  logic               rise_i,
    output logic [FRAME_W-1:0] shift_o,
    output logic               done_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [FRAME_W-1:0] shift_q;
    logic             take_bit;
    logic             last_bit;

    assign take_bit = (state_q == ST_SHIFT) && rise_i && !cs_n_i;
    assign last_bit = (bit_cnt_q == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: select, complete, abort, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_n_i)             state_d = ST_SHIFT;
            ST_SHIFT: if (cs_n_i)              state_d = ST_IDLE;
                      else if (take_bit && last_bit) state_d = ST_FULL;
            ST_FULL:  if (cs_n_i)              state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // bit counter and shift buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
        end else begin
            if (cs_n_i)        bit_cnt_q <= '0;
            else if (take_bit) bit_cnt_q <= bit_cnt_q + 1'b1;
            if (take_bit)      shift_q   <= {shift_q[FRAME_W-2:0], mosi_i};
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= take_bit && last_bit;
    end

    assign shift_o = shift_q;

    // R8: chip select high clears the bit count
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (bit_cnt_q == '0));
    // R7: after a full frame, serial edges leave the buffer untouched
    shift_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |=> $stable(shift_q));
    // R5: an abort never yields a completion strobe
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_n_i) |=> !done_o);
    // R4: completion is a single-cycle event
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4: completion only follows entry into the full state
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_FULL));
endmodule

// File: rtl/rfrx_unpack.sv
`timescale 1ns/1ps
module rfrx_unpack #(
    parameter int unsigned REGS  = 25,
    parameter int unsigned RBITS = 8,
    localparam int unsigned FRAME_W = REGS * RBITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] shift_i,
    output logic [FRAME_W-1:0] frame_data_o,
    output logic               frame_valid_o
);
    logic [FRAME_W-1:0] ordered;

    // first byte shifted in sits at the top of the buffer; place it at register 0
    for (genvar g = 0; g < REGS; g++) begin : g_reg
        assign ordered[g*RBITS +: RBITS] = shift_i[(REGS-1-g)*RBITS +: RBITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_data_o  <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= load_i;
            if (load_i) frame_data_o <= ordered;
        end
    end

    // R6: frame bus holds unless a load occurs
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(frame_data_o));
    // R4: valid strobe lasts one cycle
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);
endmodule

// File: rtl/regframe_spi_rx.sv
`timescale 1ns/1ps
module regframe_spi_rx
    import rfrx_pkg::*;
#(
    parameter int unsigned REGS  = REG_COUNT,
    parameter int unsigned RBITS = REG_BITS,
    localparam int unsigned FRAME_W = REGS * RBITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    output logic [FRAME_W-1:0] frame_data,
    output logic               frame_valid
);
    logic [2:0]         sync_v;
    logic               sclk_s, mosi_s, cs_n_s;
    logic               sclk_rise;
    logic [FRAME_W-1:0] shift_w;
    logic               done_w;

    rfrx_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_mosi, spi_sclk}),
        .sync_o  (sync_v)
    );

    assign sclk_s = sync_v[0];
    assign mosi_s = sync_v[1];
    assign cs_n_s = sync_v[2];

    rfrx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_s),
        .rise_o (sclk_rise)
    );

    rfrx_collect #(.FRAME_W(FRAME_W)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (cs_n_s),
        .mosi_i  (mosi_s),
        .rise_i  (sclk_rise),
        .shift_o (shift_w),
        .done_o  (done_w)
    );

    rfrx_unpack #(.REGS(REGS), .RBITS(RBITS)) u_unpack (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (done_w),
        .shift_i       (shift_w),
        .frame_data_o  (frame_data),
        .frame_valid_o (frame_valid)
    );

    // R5: a strobe is only produced while the transaction is still selected
    valid_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(!cs_n_s, 2));
endmodule

// File: tb/regframe_spi_rx_tb.sv
`timescale 1ns/1ps
module regframe_spi_rx_tb;
    localparam int NREG = 25;
    localparam int FW   = NREG * 8;
    localparam int HALF = 20;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic [FW-1:0] frame_data;
    logic frame_valid;

    int checks = 0, fails = 0;
    int pulses = 0, wide = 0, cyc = 0;
    logic vprev = 1'b0;
    logic [7:0] fr [NREG];
    logic [FW-1:0] exp_data;

    always #2 clk = ~clk;

    regframe_spi_rx u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_cs_n(cs_n), .frame_data(frame_data), .frame_valid(frame_valid)
    );

    always @(negedge clk) begin
        if (frame_valid) pulses++;
        if (frame_valid && vprev) wide++;
        vprev <= frame_valid;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected<=%0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [FW-1:0] pack_frame();
        logic [FW-1:0] v;
        for (int k = 0; k < NREG; k++) v[k*8 +: 8] = fr[k];
        return v;
    endfunction

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            #HALF sclk = 1'b1;
            #HALF sclk = 1'b0;
        end
    endtask

    // full bytes from fr, then extra_bits more bits of pattern 0xA5
    task automatic xfer(input int nbytes, input int extra_bits);
        @(negedge clk);
        cs_n = 1'b0;
        #HALF;
        for (int k = 0; k < nbytes; k++) send_bits(fr[k % NREG], 8);
        if (extra_bits > 0) send_bits(8'hA5, extra_bits);
        #HALF cs_n = 1'b1;
        #(HALF*3);
    endtask

    task automatic t_reset();
        check(frame_valid == 1'b0, "R1 valid", FW'(frame_valid), '0);
        check(frame_data == '0, "R1 data", frame_data, '0);
    endtask

    task automatic t_full(input string tag);
        int p0 = pulses;
        xfer(NREG, 0);
        exp_data = pack_frame();
        check(pulses == p0 + 1, {tag, " R4 pulse count"}, FW'(pulses - p0), FW'(1));
        check(frame_data == exp_data, {tag, " R3 data"}, frame_data, exp_data);
        check(wide == 0, {tag, " R4 width"}, FW'(wide), '0);
    endtask

    task automatic t_incr();
        for (int k = 0; k < NREG; k++) fr[k] = 8'(k + 1);
        t_full("R2/R3 incrementing");
    endtask

    task automatic t_msb();
        for (int k = 0; k < NREG; k++) fr[k] = (k % 2) ? 8'h01 : 8'h80;
        t_full("R2 msb-first");
    endtask

    task automatic t_trunc();
        logic [FW-1:0] held = frame_data;
        int p0 = pulses;
        for (int k = 0; k < NREG; k++) fr[k] = 8'hFF;
        xfer(24, 7);
        check(pulses == p0, "R5 no pulse", FW'(pulses - p0), '0);
        check(frame_data == held, "R5/R6 data held", frame_data, held);
    endtask

    task automatic t_after_abort();
        for (int k = 0; k < NREG; k++) fr[k] = 8'(8'h3C ^ 8'(k * 7));
        t_full("R9 after abort");
    endtask

    task automatic t_overrun();
        int p0 = pulses;
        for (int k = 0; k < NREG; k++) fr[k] = 8'(8'hC0 + k);
        exp_data = pack_frame();
        xfer(NREG + 2, 5);
        check(pulses == p0 + 1, "R7 single pulse", FW'(pulses - p0), FW'(1));
        check(frame_data == exp_data, "R7 data unaffected", frame_data, exp_data);
    endtask

    task automatic t_idle_sclk();
        int p0 = pulses;
        mosi = 1'b1;
        for (int i = 0; i < 37; i++) begin
            #HALF sclk = 1'b1;
            #HALF sclk = 1'b0;
        end
        #(HALF*3);
        check(pulses == p0, "R8 idle edges no pulse", FW'(pulses - p0), '0);
        for (int k = 0; k < NREG; k++) fr[k] = 8'(8'h5A - k);
        t_full("R8 after idle edges");
    endtask

    task automatic t_back2back();
        int p0 = pulses;
        for (int k = 0; k < NREG; k++) fr[k] = 8'h00;
        xfer(NREG, 0);
        check(frame_data == '0, "R10 first frame zeros", frame_data, '0);
        for (int k = 0; k < NREG; k++) fr[k] = 8'hFF;
        xfer(NREG, 0);
        exp_data = pack_frame();
        check(frame_data == exp_data, "R10 second frame ones", frame_data, exp_data);
        check(pulses == p0 + 2, "R10 two pulses", FW'(pulses - p0), FW'(2));
    endtask

    task automatic t_hold();
        logic [FW-1:0] held = frame_data;
        #(HALF*40);
        check(frame_data == held, "R6 idle hold", frame_data, held);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_incr();
        t_msb();
        t_trunc();
        t_after_abort();
        t_overrun();
        t_idle_sclk();
        t_back2back();
        t_hold();
        summary();
    end
endmodule